// File: doc/BRIEF.md
# Powered-Port Signature Detection and Classification Sequencer

This block decides, for one cable port of a power-sourcing switch, whether the attached device may receive 48 V. It commands two low probe levels in turn, takes one current sample from an external converter at each level, and computes the resistance as the voltage step divided by the current step. This uses a multicycle sequential divider. Only a slope inside the accept window counts as a powered device. Because the decision is made from the difference between two points, a constant leakage or offset current has no effect on it.

After a valid signature the sequencer commands the classification level. It averages a fixed number of current samples, maps the mean to a power class and reports the power budget of that class. A slope outside the window sends the port through a programmable back-off delay and back to idle. A classification current outside every band parks the port in a fault state until it is aborted. The analog drivers and the converter are outside the block: the block only issues a drive code and consumes a sample stream.

Top module: `poe_port_seq`

## Requirements
- R1: After reset, drive_cmd is 0 (off), power_en, sig_bad and cls_fault are 0, and ready is 1.
- R2: power_en is asserted only after a measured resistance R within 19000..26500 ohm inclusive. R is computed as (V_HI_MV - V_LO_MV) * 1000 / (I_hi - I_lo), in whole ohms, with the currents in microamps. A constant offset added to both currents does not change the result.
- R3: On start in idle, drive_cmd goes to 1 (low probe) and then to 2 (high probe). Each level is held for at least SETTLE+1 cycles before its sample is taken. If I_hi <= I_lo, the signature is invalid.
- R4: An invalid signature sets sig_bad. The port then stays not ready, with drive_cmd 0, for exactly max(backoff_len,1) cycles before ready returns. A start pulse during this time is ignored.
- R5: drive_cmd 3 (classification level) appears only after an accepted signature, and never in a run that ends with sig_bad.
- R6: The classification current is the mean of NAVG consecutive valid samples, taken after the settle time.
- R7: Class bands, in microamps of mean current: 0..4000 gives class 0, 9000..12000 class 1, 17000..20000 class 2, and 26000..30000 class 3. Each class is reported on pwr_class, with budget_mw of 12950, 3840, 6490 and 12950 mW for classes 0 to 3.
- R8: A mean current above 30000 uA, or in a gap between bands, asserts cls_fault. power_en stays 0 and cls_fault is held until abort.
- R9: abort returns the port to idle on the next cycle from any state, removing power_en and clearing sig_bad.
- R10: The resistance is evaluated only after the divider reports done. At least NUM_W cycles with drive_cmd 0 separate the high probe from classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a detection run (acted on in idle only) |
| abort | input | 1 | Return to idle from any state |
| backoff_len | input | BO_W | Back-off length in cycles after an invalid signature (0 acts as 1) |
| adc_valid | input | 1 | Current sample valid |
| adc_data | input | ADC_W | Port current sample in microamps |
| drive_cmd | output | 2 | Port drive: 0 off, 1 low probe, 2 high probe, 3 classification |
| ready | output | 1 | Sequencer idle |
| power_en | output | 1 | Request to apply 48 V |
| pwr_class | output | 2 | Assigned class, valid while power_en |
| budget_mw | output | 14 | Power budget in mW, valid while power_en |
| sig_bad | output | 1 | Last run found an invalid signature |
| cls_fault | output | 1 | Classification current out of every band |

## Verification
The bench sweeps the modelled device resistance across both window edges, with varying offset currents. A design that used a single-point threshold instead of the slope would misjudge the offset cases, and an off-by-one window compare would flip 19000 or 26500. It then sweeps the classification current in 500 uA steps across every band edge and gap. An alternating ripple is added to the samples, so a design that used one sample instead of the mean would pick a wrong class. Back-off length, ignored starts during back-off, reversed probe currents, the divider wait and abort from grant and fault are each measured at the ports. A premature evaluate would show up as a too-short off gap before classification.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE_LO,
        ST_PROBE_HI,
        ST_DIVIDE,
        ST_EVAL,
        ST_CLASSIFY,
        ST_GRANT,
        ST_BACKOFF,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_LO  = 2'd1,
        DRV_HI  = 2'd2,
        DRV_CLS = 2'd3
    } drive_e;

    localparam int SIG_MIN_OHM = 19000;
    localparam int SIG_MAX_OHM = 26500;

    localparam int C0_HI_UA = 4000;
    localparam int C1_LO_UA = 9000;
    localparam int C1_HI_UA = 12000;
    localparam int C2_LO_UA = 17000;
    localparam int C2_HI_UA = 20000;
    localparam int C3_LO_UA = 26000;
    localparam int C3_HI_UA = 30000;

    localparam int BUD_W = 14;

    typedef struct packed {
        logic       fault;
        logic [1:0] cls;
    } class_res_t;

    function automatic logic [BUD_W-1:0] class_budget(input logic [1:0] c);
        case (c)
            2'd1:    return BUD_W'(3840);
            2'd2:    return BUD_W'(6490);
            default: return BUD_W'(12950);
        endcase
    endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int NUM_W = 22,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] q_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, q_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            den_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                q_q   <= num;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                q_q   <= {q_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_q;

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R10
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

endmodule

// File: rtl/cls_averager.sv
module cls_averager #(
    parameter int ADC_W = 16,
    parameter int NAVG  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [ADC_W-1:0] sample,
    output logic             done,
    output logic [ADC_W-1:0] avg
);
    localparam int LOG_N = $clog2(NAVG);
    localparam int CNT_W = $clog2(NAVG + 1);
    localparam int SUM_W = ADC_W + LOG_N;

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (en && !done) begin
            sum_q <= sum_q + SUM_W'(sample);
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(NAVG - 1)) done <= 1'b1;
        end
    end

    assign avg = ADC_W'(sum_q >> LOG_N);

    AST_AVG_COUNT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NAVG)); // R6
    AST_AVG_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> cnt_q == CNT_W'(NAVG)); // R6

endmodule

// File: rtl/cls_decoder.sv
module cls_decoder
    import poe_seq_pkg::*;
#(
    parameter int ADC_W = 16
) (
    input  logic [ADC_W-1:0] avg,
    output class_res_t       res
);
    always_comb begin
        res = '{fault: 1'b1, cls: 2'd0};
        if (avg <= ADC_W'(C0_HI_UA))
            res = '{fault: 1'b0, cls: 2'd0};
        else if (avg >= ADC_W'(C1_LO_UA) && avg <= ADC_W'(C1_HI_UA))
            res = '{fault: 1'b0, cls: 2'd1};
        else if (avg >= ADC_W'(C2_LO_UA) && avg <= ADC_W'(C2_HI_UA))
            res = '{fault: 1'b0, cls: 2'd2};
        else if (avg >= ADC_W'(C3_LO_UA) && avg <= ADC_W'(C3_HI_UA))
            res = '{fault: 1'b0, cls: 2'd3};
    end
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int ADC_W    = 16,
    parameter int SETTLE   = 8,
    parameter int NAVG     = 4,
    parameter int V_LO_MV  = 4000,
    parameter int V_HI_MV  = 8000,
    parameter int BO_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [BO_W-1:0]  backoff_len,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_data,
    output logic [1:0]       drive_cmd,
    output logic             ready,
    output logic             power_en,
    output logic [1:0]       pwr_class,
    output logic [13:0]      budget_mw,
    output logic             sig_bad,
    output logic             cls_fault
);
    localparam int DV_NUM = (V_HI_MV - V_LO_MV) * 1000;
    localparam int NUM_W  = $clog2(DV_NUM + 1);
    localparam int SET_W  = $clog2(SETTLE + 1);

    seq_state_e       state_q;
    logic [SET_W-1:0] settle_q;
    logic [ADC_W-1:0] i_lo_q;
    logic [BO_W:0]    bo_cnt_q;
    logic [BO_W:0]    bo_len_eff;
    logic [1:0]       cls_q;
    logic [BUD_W-1:0] budget_q;
    logic             sig_bad_q;

    logic             settled;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] quot;
    logic             sig_ok;
    logic             avg_en;
    logic             avg_clr;
    logic             avg_done;
    logic [ADC_W-1:0] avg;
    class_res_t       dec;

    assign settled    = settle_q == SET_W'(SETTLE);
    assign div_start  = (state_q == ST_PROBE_HI) && settled && adc_valid && (adc_data > i_lo_q);
    assign avg_clr    = state_q != ST_CLASSIFY;
    assign avg_en     = (state_q == ST_CLASSIFY) && settled && adc_valid;
    assign bo_len_eff = (backoff_len == '0) ? (BO_W+1)'(1) : {1'b0, backoff_len};
    assign sig_ok     = (quot >= NUM_W'(SIG_MIN_OHM)) && (quot <= NUM_W'(SIG_MAX_OHM));

    seq_divider #(.NUM_W(NUM_W), .DEN_W(ADC_W)) i_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (NUM_W'(DV_NUM)),
        .den   (adc_data - i_lo_q),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (quot)
    );

    cls_averager #(.ADC_W(ADC_W), .NAVG(NAVG)) i_avg (
        .clk    (clk),
        .rst    (rst),
        .clr    (avg_clr),
        .en     (avg_en),
        .sample (adc_data),
        .done   (avg_done),
        .avg    (avg)
    );

    cls_decoder #(.ADC_W(ADC_W)) i_dec (
        .avg (avg),
        .res (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            settle_q  <= '0;
            i_lo_q    <= '0;
            bo_cnt_q  <= '0;
            cls_q     <= '0;
            budget_q  <= '0;
            sig_bad_q <= 1'b0;
        end else if (abort) begin
            state_q   <= ST_IDLE;
            settle_q  <= '0;
            sig_bad_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    settle_q <= '0;
                    if (start) begin
                        sig_bad_q <= 1'b0;
                        state_q   <= ST_PROBE_LO;
                    end
                end
                ST_PROBE_LO: begin
                    if (!settled) settle_q <= settle_q + 1'b1;
                    else if (adc_valid) begin
                        i_lo_q   <= adc_data;
                        settle_q <= '0;
                        state_q  <= ST_PROBE_HI;
                    end
                end
                ST_PROBE_HI: begin
                    if (!settled) settle_q <= settle_q + 1'b1;
                    else if (adc_valid) begin
                        settle_q <= '0;
                        if (adc_data > i_lo_q) state_q <= ST_DIVIDE;
                        else begin
                            state_q   <= ST_BACKOFF;
                            sig_bad_q <= 1'b1;
                            bo_cnt_q  <= '0;
                        end
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (sig_ok) state_q <= ST_CLASSIFY;
                    else begin
                        state_q   <= ST_BACKOFF;
                        sig_bad_q <= 1'b1;
                        bo_cnt_q  <= '0;
                    end
                end
                ST_CLASSIFY: begin
                    if (!settled) settle_q <= settle_q + 1'b1;
                    if (avg_done) begin
                        if (dec.fault) state_q <= ST_FAULT;
                        else begin
                            cls_q    <= dec.cls;
                            budget_q <= class_budget(dec.cls);
                            state_q  <= ST_GRANT;
                        end
                    end
                end
                ST_BACKOFF: begin
                    bo_cnt_q <= bo_cnt_q + 1'b1;
                    if (bo_cnt_q + 1'b1 >= bo_len_eff) state_q <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_PROBE_LO: drive_cmd = DRV_LO;
            ST_PROBE_HI: drive_cmd = DRV_HI;
            ST_CLASSIFY: drive_cmd = DRV_CLS;
            default:     drive_cmd = DRV_OFF;
        endcase
    end

    assign ready     = state_q == ST_IDLE;
    assign power_en  = state_q == ST_GRANT;
    assign cls_fault = state_q == ST_FAULT;
    assign sig_bad   = sig_bad_q;
    assign pwr_class = cls_q;
    assign budget_mw = budget_q;

    AST_PWR_NO_BAD_SIG: assert property (@(posedge clk) disable iff (rst)
        power_en |-> !sig_bad); // R2
    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        (drive_cmd == DRV_HI && $past(drive_cmd) != DRV_HI) |-> $past(drive_cmd) == DRV_LO); // R3
    AST_BACKOFF_NO_START: assert property (@(posedge clk) disable iff (rst || abort)
        (state_q == ST_BACKOFF && bo_cnt_q + 1'b1 < bo_len_eff) |=> state_q == ST_BACKOFF); // R4
    AST_CLS_AFTER_EVAL: assert property (@(posedge clk) disable iff (rst)
        (drive_cmd == DRV_CLS && $past(drive_cmd) != DRV_CLS) |-> $past(state_q) == ST_EVAL); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cls_fault && !abort) |=> cls_fault); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (ready && !power_en)); // R9
    AST_EVAL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EVAL |-> $past(div_done)); // R10

endmodule

// File: tb/test_poe_port_seq.sv
`timescale 1ns/1ps
module test_poe_port_seq;
    localparam int SETTLE = 8;
    localparam int NUM_W  = $clog2(4000 * 1000 + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [15:0] backoff_len = 16'd4;
    logic        adc_valid = 1'b1;
    logic [15:0] adc_data;
    logic [1:0]  drive_cmd;
    logic        ready, power_en, sig_bad, cls_fault;
    logic [1:0]  pwr_class;
    logic [13:0] budget_mw;

    int checks = 0;
    int fails  = 0;
    int m_r = 25000, m_off = 0, m_icl = 10000;
    bit m_rev = 1'b0;
    bit alt = 1'b0;
    bit cls_seen = 1'b0;
    int run_len = 0;
    int lo_len = 0, hi_len = 0, off_before_cls = 0;
    logic [1:0] prev_drv = 2'd0;

    always #10 clk = ~clk;

    poe_port_seq i_poe_port_seq (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .backoff_len(backoff_len), .adc_valid(adc_valid), .adc_data(adc_data),
        .drive_cmd(drive_cmd), .ready(ready), .power_en(power_en),
        .pwr_class(pwr_class), .budget_mw(budget_mw),
        .sig_bad(sig_bad), .cls_fault(cls_fault)
    );

    function automatic int i_at(input int v_mv, input int r, input int off);
        return off + (v_mv * 1000) / r;
    endfunction

    always_comb begin
        int v;
        case (drive_cmd)
            2'd1: v = i_at(4000, m_r, m_off);
            2'd2: v = m_rev ? i_at(4000, m_r, m_off) - 10 : i_at(8000, m_r, m_off);
            2'd3: v = m_icl + ((m_icl >= 1000) ? (alt ? 250 : -250) : 0);
            default: v = 0;
        endcase
        adc_data = 16'(v);
    end

    always @(negedge clk) begin
        alt <= ~alt;
        if (drive_cmd == 2'd3) cls_seen <= 1'b1;
        if (drive_cmd != prev_drv) begin
            if (prev_drv == 2'd1) lo_len <= run_len;
            if (prev_drv == 2'd2) hi_len <= run_len;
            if (prev_drv == 2'd0 && drive_cmd == 2'd3) off_before_cls <= run_len;
            run_len <= 1;
        end else run_len <= run_len + 1;
        prev_drv <= drive_cmd;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    // outcome: 0 grant, 1 invalid signature, 2 class fault, 3 timeout
    task automatic run_case(input int r, input int off, input int icl, input bit rev,
                            output int outcome);
        m_r = r; m_off = off; m_icl = icl; m_rev = rev;
        cls_seen = 1'b0;
        pulse_start();
        outcome = 3;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (power_en) begin outcome = 0; break; end
            if (sig_bad)  begin outcome = 1; break; end
            if (cls_fault) begin outcome = 2; break; end
        end
    endtask

    task automatic settle_idle();
        if (!ready) begin
            if (power_en || cls_fault) do_abort();
            for (int k = 0; k < 2000 && !ready; k++) @(negedge clk);
        end
    endtask

    function automatic int exp_sig(input int r, input int off, input bit rev);
        int a, b, q;
        a = i_at(4000, r, off);
        b = rev ? a - 10 : i_at(8000, r, off);
        if (b <= a) return 0;
        q = 4000000 / (b - a);
        return (q >= 19000 && q <= 26500) ? 1 : 0;
    endfunction

    function automatic int exp_cls(input int i);
        if (i <= 4000) return 0;
        if (i >= 9000 && i <= 12000) return 1;
        if (i >= 17000 && i <= 20000) return 2;
        if (i >= 26000 && i <= 30000) return 3;
        return -1;
    endfunction

    function automatic int exp_bud(input int c);
        case (c)
            1: return 3840;
            2: return 6490;
            default: return 12950;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int oc, ec, t0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(drive_cmd == 2'd0, "R1 drive_cmd", drive_cmd, 0);
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(!power_en && !sig_bad && !cls_fault, "R1 status", {power_en, sig_bad, cls_fault}, 0);

        // R3 settle and order; R10 divider gap
        run_case(25000, 0, 10000, 1'b0, oc);
        chk(oc == 0, "R2 nominal grant", oc, 0);
        chk(lo_len >= SETTLE + 1, "R3 low probe hold", lo_len, SETTLE + 1);
        chk(hi_len >= SETTLE + 1, "R3 high probe hold", hi_len, SETTLE + 1);
        chk(off_before_cls >= NUM_W, "R10 divider wait gap", off_before_cls, NUM_W);
        chk(cls_seen, "R5 classification seen after accept", cls_seen, 1);
        // R9 abort from grant
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk(!power_en && ready, "R9 abort from grant", {power_en, ready}, 1);

        // R2 sweep of resistance with offsets
        for (int r = 15000; r <= 30000; r += 500) begin
            int off;
            off = ((r / 500) * 37) % 200;
            run_case(r, off, 10500, 1'b0, oc);
            ec = exp_sig(r, off, 1'b0) ? 0 : 1;
            chk(oc == ec, $sformatf("R2 slope r=%0d off=%0d", r, off), oc, ec);
            if (ec == 1) chk(!cls_seen, "R5 no classification on bad sig", cls_seen, 0);
            settle_idle();
        end

        // R3 reversed currents
        run_case(25000, 100, 10000, 1'b1, oc);
        chk(oc == 1, "R3 reversed probe currents", oc, 1);
        settle_idle();

        // R4 back-off length and ignored start
        backoff_len = 16'd25;
        run_case(50000, 0, 10000, 1'b0, oc);
        chk(oc == 1, "R4 invalid signature", oc, 1);
        t0 = 0;
        for (int k = 0; k < 100 && !ready; k++) begin
            if (k == 10) start = 1'b1;
            if (k == 11) start = 1'b0;
            if (drive_cmd != 2'd0) t0 = 1000;
            @(negedge clk);
            t0++;
        end
        start = 1'b0;
        chk(t0 == 25, "R4 back-off cycles with ignored start", t0, 25);
        chk(sig_bad, "R4 sig_bad held", sig_bad, 1);
        backoff_len = 16'd0;
        run_case(50000, 0, 10000, 1'b0, oc);
        t0 = 0;
        for (int k = 0; k < 100 && !ready; k++) begin @(negedge clk); t0++; end
        chk(t0 == 1, "R4 zero back-off acts as one", t0, 1);
        backoff_len = 16'd4;

        // R6 R7 R8 classification sweep
        for (int i = 0; i <= 32000; i += 500) begin
            run_case(25000, 0, i, 1'b0, oc);
            ec = exp_cls(i);
            if (ec < 0) begin
                chk(oc == 2, $sformatf("R8 fault i=%0d", i), oc, 2);
            end else begin
                chk(oc == 0, $sformatf("R6 grant i=%0d", i), oc, 0);
                chk(pwr_class == 2'(ec), $sformatf("R7 class i=%0d", i), pwr_class, ec);
                chk(budget_mw == 14'(exp_bud(ec)), $sformatf("R7 budget i=%0d", i),
                    budget_mw, exp_bud(ec));
            end
            settle_idle();
        end

        // R8 fault hold then R9 abort
        run_case(25000, 0, 31000, 1'b0, oc);
        repeat (50) @(negedge clk);
        chk(cls_fault && !power_en, "R8 fault held", {cls_fault, power_en}, 2);
        do_abort();
        chk(ready && !cls_fault, "R9 abort from fault", {ready, cls_fault}, 2);

        // R9 abort mid-detection
        m_r = 25000; m_off = 0; m_rev = 1'b0;
        pulse_start();
        repeat (3) @(negedge clk);
        do_abort();
        chk(ready && drive_cmd == 2'd0, "R9 abort mid-probe", drive_cmd, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule